// File: doc/BRIEF.md
# ADC Serial Configuration and Result Port

This block is the converter-side digital serial port of a 16-bit multichannel successive-approximation converter. A host drives a conversion strobe, a serial clock and a serial data line. Each frame between conversions does two things at once. It shifts a 14-bit setup word into the port on rising serial-clock edges. It also shifts out the coded result of the last finished conversion on falling edges. The setup can ask for the setup word of that conversion to follow the result. It can also ask for a leading ready bit on the data line, which then serves as a busy indicator.

All pins are sampled into the system clock domain through a synchronizer. Edges are detected on the synchronized levels. A conversion runs for a programmable number of system clocks. An analog sample is presented as a signed integer in LSB units and is coded when the conversion starts. A separate output-enable port shows when the data line would be driven, so high-impedance timing can be observed directly.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `busy` and `sdo_oe` are low, and the active setup is `RST_CFG` (unipolar, no readback, no ready bit).
- R2: The setup word is taken MSB first, bit 13 first, one bit per rising serial-clock edge. Bit 13 selects bipolar coding, bit 12 enables readback, bit 11 enables the ready bit, and bits 10:0 are spare but stored and read back.
- R3: The 16-bit result appears on `sdo` MSB first. The next bit is presented on each falling serial-clock edge.
- R4: Without the ready bit, `sdo_oe` drops on the 16th falling edge, or on the 30th when readback is on. Before that point it stays high and the data line carries the remaining bits.
- R5: With the ready bit, `sdo` shows a 1 ahead of the result MSB, and the frame is one edge longer: `sdo_oe` drops on the 17th falling edge, or on the 31st with readback.
- R6: With the ready bit, if the host supplies fewer falling edges than the frame needs, the last presented bit stays driven until the next conversion starts.
- R7: The readback word that follows the result is the setup in force for the conversion being read. It is not the word being shifted in during the same frame.
- R8: Bipolar coding gives two's complement, saturating at 0x7FFF and 0x8000. Unipolar coding gives straight binary, saturating at 0xFFFF above range and at 0x0000 below zero.
- R9: A rising edge of `cnv` while idle holds `busy` high for exactly `CONV_CYC` system clocks.
- R10: Serial-clock edges during a conversion neither capture setup bits nor shift the output.
- R11: A setup word becomes active at the next conversion start only if all 14 bits arrived since the previous start. Otherwise the previous setup is kept.
- R12: During a conversion, `sdo_oe` is low without the ready bit. With the ready bit, `sdo_oe` is high and `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Conversion strobe, rising edge starts a conversion |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial setup data from the host |
| ain | input | AIN_W | Signed analog sample in LSB units |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | High while the data line is driven |
| busy | output | 1 | High during a conversion |

## Verification
The bench builds the port with `CONV_CYC` set to 40. This is long enough for a burst of fourteen serial-clock edges to fit inside one conversion, which tests that those edges are ignored. It is still short enough that frames of every length fit easily in the run. The bench keeps the default 14/16 word sizes and a two-stage synchronizer. With these values it can reach:
- every frame length (16, 17, 30 and 31 edges);
- both saturation limits in each coding;
- partial frames in both output modes.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  // Setup word field positions, counted from the MSB that arrives first.
  localparam int SETUP_W    = 14;
  localparam int F_BIPOLAR  = SETUP_W - 1;
  localparam int F_READBACK = SETUP_W - 2;
  localparam int F_READYBIT = SETUP_W - 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/setup_rx.sv
module setup_rx #(
  parameter int              CFG_W   = 14,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sck_rise,
  input  logic             sdi,
  input  logic             commit,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] cfg_next
);
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic [CFG_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign full     = (cnt == CNT_W'(CFG_W));
  assign cfg_next = full ? sh : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      cnt   <= '0;
      cfg_q <= RST_CFG;
    end else if (commit) begin
      cfg_q <= cfg_next;
      cnt   <= '0;
    end else if (enable && sck_rise && !full) begin
      sh  <= {sh[CFG_W-2:0], sdi};
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/result_coder.sv
module result_coder #(
  parameter int AIN_W = 18,
  parameter int RES_W = 16
) (
  input  logic signed [AIN_W-1:0] ain,
  input  logic                    bipolar,
  output logic [RES_W-1:0]        code
);
  localparam int UMAX = (1 << RES_W) - 1;
  localparam int BMAX = (1 << (RES_W - 1)) - 1;
  localparam int BMIN = -(1 << (RES_W - 1));

  logic signed [31:0] v;

  always_comb begin
    v = 32'(ain);
    if (bipolar) begin
      if (v > BMAX)      code = RES_W'(BMAX);
      else if (v < BMIN) code = RES_W'(BMIN);
      else               code = v[RES_W-1:0];
    end else begin
      if (v > UMAX)      code = RES_W'(UMAX);
      else if (v < 0)    code = '0;
      else               code = v[RES_W-1:0];
    end
  end
endmodule

// File: rtl/out_frame.sv
module out_frame #(
  parameter int RES_W = 16,
  parameter int CFG_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_ready,
  input  logic             load,
  input  logic [RES_W-1:0] res,
  input  logic [CFG_W-1:0] cfg_rb,
  input  logic             rb_en,
  input  logic             ready_en,
  input  logic             sck_fall,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int FW = RES_W + CFG_W + 1;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      left   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (start) begin
      left   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= start_ready;
    end else if (load) begin
      sh     <= ready_en ? {1'b1, res, cfg_rb} : {res, cfg_rb, 1'b0};
      sdo    <= ready_en ? 1'b1 : res[RES_W-1];
      sdo_oe <= 1'b1;
      left   <= LW'(RES_W + (rb_en ? CFG_W : 0) + (ready_en ? 1 : 0));
    end else if (sck_fall && left != '0) begin
      if (left == LW'(1)) begin
        sdo_oe <= 1'b0;
        sdo    <= 1'b0;
        left   <= '0;
      end else begin
        sh   <= sh << 1;
        sdo  <= sh[FW-2];
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int                 RES_W       = 16,
  parameter int                 AIN_W       = 18,
  parameter int                 CONV_CYC    = 40,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [SETUP_W-1:0] RST_CFG     = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cnv,
  input  logic                    sck,
  input  logic                    sdi,
  input  logic signed [AIN_W-1:0] ain,
  output logic                    sdo,
  output logic                    sdo_oe,
  output logic                    busy
);
  localparam int CW = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;

  logic [2:0]         pins_s;
  logic [1:0]         prev;
  logic               cnv_rise, sck_rise, sck_fall;
  logic               conv_start, load;
  logic [CW-1:0]      cnt;
  logic [RES_W-1:0]   code_w, res_q;
  logic [SETUP_W-1:0] cfg_act, cfg_next, cfg_conv;

  pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({cnv, sck, sdi}), .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= pins_s[2:1];
  end

  assign cnv_rise   = pins_s[2] & ~prev[1];
  assign sck_rise   = pins_s[1] & ~prev[0];
  assign sck_fall   = ~pins_s[1] & prev[0];
  assign conv_start = cnv_rise & ~busy;
  assign load       = busy && (cnt == '0);

  setup_rx #(.CFG_W(SETUP_W), .RST_CFG(RST_CFG)) u_rx (
    .clk(clk), .rst(rst), .enable(~busy), .sck_rise(sck_rise),
    .sdi(pins_s[0]), .commit(conv_start), .cfg_q(cfg_act), .cfg_next(cfg_next)
  );

  result_coder #(.AIN_W(AIN_W), .RES_W(RES_W)) u_code (
    .ain(ain), .bipolar(cfg_next[F_BIPOLAR]), .code(code_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      res_q    <= '0;
      cfg_conv <= RST_CFG;
    end else if (conv_start) begin
      busy     <= 1'b1;
      cnt      <= CW'(CONV_CYC - 1);
      res_q    <= code_w;
      cfg_conv <= cfg_next;
    end else if (load) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  out_frame #(.RES_W(RES_W), .CFG_W(SETUP_W)) u_out (
    .clk(clk), .rst(rst), .start(conv_start), .start_ready(cfg_next[F_READYBIT]),
    .load(load), .res(res_q), .cfg_rb(cfg_conv), .rb_en(cfg_conv[F_READBACK]),
    .ready_en(cfg_conv[F_READYBIT]), .sck_fall(sck_fall & ~busy),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CONV_CYC = 40,
  parameter int CFG_W    = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             sck_fall,
  input logic             conv_start,
  input logic             load,
  input logic [CFG_W-1:0] cfg_act,
  input logic             ready_conv
);
  int bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bcnt == CONV_CYC);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(cfg_act));

  assert_ready_low_R12: assert property (@(posedge clk) disable iff (rst)
    busy && ready_conv |-> sdo_oe && !sdo);

  assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    busy && !ready_conv |-> !sdo_oe);

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sdo_oe) |-> $past(sck_fall || conv_start));

  assert_drive_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(load || conv_start));
endmodule

bind adc_serial_port adc_serial_port_chk #(.CONV_CYC(CONV_CYC), .CFG_W(adc_port_pkg::SETUP_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe),
  .sck_fall(sck_fall), .conv_start(conv_start), .load(load),
  .cfg_act(cfg_act), .ready_conv(cfg_conv[adc_port_pkg::F_READYBIT])
);

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;
  localparam int CONV_CYC = 40;
  localparam int AIN_W    = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic signed [AIN_W-1:0] ain = '0;
  logic sdo, sdo_oe, busy;

  int tests = 0, fails = 0;
  string ctx = "";

  // Behavioural model state
  logic [13:0] cfg_act_m  = 14'h0;
  logic [13:0] cfg_used_m = 14'h0;
  logic [13:0] pend_m     = 14'h0;
  bit          pend_full  = 0;
  int          res_m      = 0;

  always #2 clk = ~clk;

  adc_serial_port #(.CONV_CYC(CONV_CYC), .AIN_W(AIN_W)) u0 (
    .clk(clk), .rst(rst), .cnv(cnv), .sck(sck), .sdi(sdi), .ain(ain),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, ctx, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int code_of(input int a, input bit bip);
    if (bip) begin
      if (a > 32767)  return 32'h7FFF;
      if (a < -32768) return 32'h8000;
      return a & 32'hFFFF;
    end
    if (a < 0)     return 0;
    if (a > 65535) return 32'hFFFF;
    return a;
  endfunction

  // Expected output after k falling edges of the current frame
  task automatic chk_out(input int k);
    bit rdy = cfg_used_m[11];
    bit rb  = cfg_used_m[12];
    int len = 16 + (rb ? 14 : 0) + (rdy ? 1 : 0);
    int p;
    if (k >= len) begin
      check(rdy ? "R5" : "R4", int'(sdo_oe), 0);
    end else begin
      check(rdy ? "R5" : "R4", int'(sdo_oe), 1);
      if (rdy && k == 0) check("R5", int'(sdo), 1);
      else begin
        p = rdy ? k - 1 : k;
        if (p < 16) check("R3/R8", int'(sdo), (res_m >> (15 - p)) & 1);
        else        check("R2/R7", int'(sdo), int'(cfg_used_m[13 - (p - 16)]));
      end
    end
  endtask

  task automatic frame(input logic [13:0] w, input int nclk);
    for (int k = 0; k < nclk; k++) begin
      sdi = (k < 14) ? w[13 - k] : 1'b0;
      wait_n(6);
      sck = 1'b1;
      wait_n(6);
      sck = 1'b0;
      wait_n(6);
      chk_out(k + 1);
    end
    sdi = 1'b0;
    if (nclk >= 14) begin
      pend_m    = w;
      pend_full = 1;
    end
  endtask

  task automatic convert(input int a, input bit burst);
    int  n = 0;
    bit  seen = 0;
    if (pend_full) cfg_act_m = pend_m;
    pend_full  = 0;
    cfg_used_m = cfg_act_m;
    res_m      = code_of(a, cfg_act_m[13]);
    ain = AIN_W'(a);
    cnv = 1'b1;
    for (int c = 0; c < CONV_CYC + 12; c++) begin
      if (burst && c >= 5 && c < 33) begin
        sck = ((c - 5) % 2 == 0);
        sdi = 1'b1;
      end
      @(negedge clk);
      if (busy) begin
        n++;
        if (!seen) begin
          seen = 1;
          check("R12", int'(sdo_oe), int'(cfg_used_m[11]));
          if (cfg_used_m[11]) check("R6/R12", int'(sdo), 0);
        end
      end
    end
    sck = 1'b0;
    sdi = 1'b0;
    check("R9", n, CONV_CYC);
    cnv = 1'b0;
    wait_n(6);
    chk_out(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_n(6);
    check("R1", int'(busy), 0);
    check("R1", int'(sdo_oe), 0);
    rst = 1'b0;
    wait_n(4);
    check("R1", int'(sdo_oe), 0);

    ctx = "unipolar default";
    convert(1234, 0);
    frame(14'h22A5, 16);              // bipolar, no readback, no ready bit
    ctx = "bipolar negative";
    convert(-5, 0);
    frame(14'h115A, 16);              // unipolar + readback
    ctx = "unipolar over-range readback";
    convert(70000, 0);
    frame(14'h38C3, 30);              // bipolar + readback + ready bit
    ctx = "bipolar under-range ready+readback";
    convert(-40000, 0);
    frame(14'h0811, 31);              // unipolar + ready bit
    ctx = "unipolar below zero ready";
    convert(-3, 0);
    frame(14'h207F, 17);              // bipolar, plain
    ctx = "R10 sck burst during conversion";
    convert(40000, 1);
    frame(14'h0000, 5);               // partial, must not take effect
    ctx = "R11 incomplete setup kept";
    convert(-1, 0);
    frame(14'h0800, 16);              // unipolar + ready bit
    ctx = "R6 partial ready frame";
    convert(500, 0);
    frame(14'h3FFF, 6);
    wait_n(30);
    chk_out(6);
    ctx = "R6 next start drives low";
    convert(700, 0);
    frame(14'h0000, 17);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule